// File: doc/BRIEF.md
# Dual-Edge Serial Bit Counter

This block is a small counter with its own control register. Inside a compact serial interface it counts the bits of a transfer. It is just as useful on its own: as a general event counter, as one more edge-triggered interrupt source, or as an interrupt that software raises by writing a strobe. The count can come from two places. One is a write-only strobe bit in the control register. The other is an external serial-clock pin, sampled through a two-flop synchronizer. Both the rising and the falling edge of that pin advance the count.

When the 4-bit count passes 0xF and wraps, a sticky overflow flag is set. Writing a one to the flag clears it. The interrupt output is the flag gated by an enable bit in the control register. Software can preload the count through its own port. Preloading 0xF makes the next counting event raise the flag at once, so a single pin edge or a single strobe then becomes an interrupt.

Top module: `sibc_top`

## Requirements
- R1: After reset, the control read port, the count and the overflow flag read 0 and the interrupt request is low.
- R2: Control bits 7..2 read back as last written. Bit 7 is the start-condition interrupt enable, bit 6 the overflow interrupt enable, bits 5..4 the wire mode and bits 3..2 the clock select. Bits 1 and 0 are write-only strobes and always read as 0.
- R3: A count-port write loads the value, visible one cycle later. In the same cycle it takes priority over any counting event, and no overflow results from that cycle.
- R4: A control write with bit 1 set advances the count by one in every clock-select setting. A control write with only bit 0 set does not change the count.
- R5: With clock select 1x, each rising and each falling edge of the serial-clock pin advances the count by one. The new count is visible three clock edges after the pin changes. With clock select 00 or 01, pin edges are ignored.
- R6: A wrap from 0xF to 0x0 sets the overflow flag. With 0xF preloaded, a single pin edge sets it.
- R7: Writing 1 to the flag clears it and writing 0 leaves it unchanged. An overflow in the same cycle as a clear keeps the flag set.
- R8: The interrupt request equals flag AND the overflow interrupt enable (bit 6). It rises in the cycle after the enable is written if the flag is already pending.
- R9: A strobe and a pin edge in the same cycle advance the count by two. If that step passes 0xF, the flag is set.
- R10: The wire-mode bits have no effect on counting from either source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sck_pin | input | 1 | External serial-clock pin, asynchronous |
| ctl_wr_en | input | 1 | Control register write enable |
| ctl_wr_data | input | 8 | Control register write data |
| ctl_rd_data | output | 8 | Control register read data |
| cnt_wr_en | input | 1 | Count write enable |
| cnt_wr_data | input | 4 | Count write data |
| cnt_rd_data | output | 4 | Current count |
| ovf_wr_en | input | 1 | Overflow flag write enable |
| ovf_wr_data | input | 1 | Flag write data; 1 clears |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Interrupt request |

## Verification
Counting is driven three ways: by software strobes alone, by rising and falling pin edges alone, and by both landing in the same cycle. The first shows that the strobe counts in every clock-select setting. The second shows that both edge polarities count and that the pin is ignored in the software-only settings. The third tells a two-step advance apart from a lost event. Preloads of 0xE and 0xF separate a normal wrap, a double-step wrap and a one-edge interrupt, while collisions of a bus write or a flag clear with a counting event show which side wins.

// File: rtl/sibc_pkg.sv
// Shared types for the serial bit counter.
// Assumes an 8-bit control register whose two low bits are write-only strobes.
package sibc_pkg;
    localparam int CTL_W       = 8;
    localparam int CTL_STATE_W = CTL_W - 2;
    localparam int BIT_SOFT    = 1;
    localparam int BIT_TOGGLE  = 0;

    typedef enum logic [1:0] {
        CS_SOFT_ONLY = 2'b00,
        CS_SOFT_ALT  = 2'b01,
        CS_PIN_A     = 2'b10,
        CS_PIN_B     = 2'b11
    } clk_sel_e;

    typedef struct packed {
        logic       start_ie;
        logic       ovf_ie;
        logic [1:0] wire_mode;
        clk_sel_e   clk_sel;
    } ctl_state_t;
endpackage

// File: rtl/sibc_ctl_reg.sv
// Control register: holds the six read/write bits and decodes the two
// write-only strobe bits into single-cycle pulses.
// Assumes the bus write is a single-cycle enable with the data valid alongside it.
module sibc_ctl_reg
    import sibc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wr_data,
    output ctl_state_t       state,
    output logic             soft_strobe,
    output logic [CTL_W-1:0] rd_data
);
    // Stored read/write bits, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= '0;
        else if (wr_en)
            state <= ctl_state_t'(wr_data[CTL_W-1:2]);
    end

    // Strobe pulse follows the write; the toggle strobe has no counting role.
    always_comb soft_strobe = wr_en & wr_data[BIT_SOFT];

    // Read data: stored bits on top, strobe positions read as zero.
    always_comb rd_data = {state, 2'b00};
endmodule

// File: rtl/sibc_edge_sync.sv
// Synchronizes an asynchronous pin and flags each change of level,
// rising or falling, as a one-cycle pulse.
// Assumes the pin stays at a level for at least two system clocks.
module sibc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic edge_pulse
);
    localparam int CHAIN_W = STAGES + 1;

    logic [CHAIN_W-1:0] chain;

    // Synchronizer stages plus one history flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n)
            chain <= '0;
        else
            chain <= {chain[CHAIN_W-2:0], pin};
    end

    // Any level difference between the last two samples is an edge.
    always_comb edge_pulse = chain[CHAIN_W-1] ^ chain[CHAIN_W-2];
endmodule

// File: rtl/sibc_bit_counter.sv
// Wrapping counter with a sticky overflow flag. Up to two step sources
// may fire in one cycle. A bus load overrides both and suppresses overflow.
// An overflow wins over a same-cycle write-one-to-clear.
module sibc_bit_counter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_en,
    input  logic [W-1:0] load_val,
    input  logic         step_a,
    input  logic         step_b,
    input  logic         clr_en,
    input  logic         clr_bit,
    output logic [W-1:0] count,
    output logic         flag
);
    localparam int SUM_W = W + 1;

    logic [1:0]       inc;
    logic [SUM_W-1:0] sum;
    logic             wrap;

    // Number of counting events this cycle and the widened next count.
    always_comb begin
        inc  = {1'b0, step_a} + {1'b0, step_b};
        sum  = {1'b0, count} + SUM_W'(inc);
        wrap = !load_en && sum[W];
    end

    // Count register: a bus load takes priority over counting.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (load_en)
            count <= load_val;
        else
            count <= sum[W-1:0];
    end

    // Overflow flag: set on wrap, otherwise cleared by writing one.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag <= 1'b0;
        else if (wrap)
            flag <= 1'b1;
        else if (clr_en && clr_bit)
            flag <= 1'b0;
    end
endmodule

// File: rtl/sibc_top.sv
// Top level of the serial bit counter. It joins the control register, the
// pin edge detector and the counter, and gates the interrupt output.
// Assumes a single clock domain apart from the serial-clock pin.
module sibc_top
    import sibc_pkg::*;
#(
    parameter int CNT_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sck_pin,
    input  logic             ctl_wr_en,
    input  logic [CTL_W-1:0] ctl_wr_data,
    output logic [CTL_W-1:0] ctl_rd_data,
    input  logic             cnt_wr_en,
    input  logic [CNT_W-1:0] cnt_wr_data,
    output logic [CNT_W-1:0] cnt_rd_data,
    input  logic             ovf_wr_en,
    input  logic             ovf_wr_data,
    output logic             ovf_flag,
    output logic             irq
);
    ctl_state_t ctl;
    logic       soft_strobe;
    logic       pin_edge;
    logic       pin_step;

    sibc_ctl_reg u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (ctl_wr_en),
        .wr_data     (ctl_wr_data),
        .state       (ctl),
        .soft_strobe (soft_strobe),
        .rd_data     (ctl_rd_data)
    );

    sibc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin        (sck_pin),
        .edge_pulse (pin_edge)
    );

    // Pin edges count only when the high clock-select bit is set.
    always_comb pin_step = pin_edge & ctl.clk_sel[1];

    sibc_bit_counter #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (cnt_wr_en),
        .load_val (cnt_wr_data),
        .step_a   (soft_strobe),
        .step_b   (pin_step),
        .clr_en   (ovf_wr_en),
        .clr_bit  (ovf_wr_data),
        .count    (cnt_rd_data),
        .flag     (ovf_flag)
    );

    // Interrupt request: pending flag gated by its enable.
    always_comb irq = ovf_flag & ctl.ovf_ie;
endmodule

// File: rtl/sibc_top_chk.sv
// Port-level assertions for sibc_top, attached by bind.
module sibc_top_chk #(
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [7:0]       ctl_wr_data,
    input logic             ctl_wr_en,
    input logic [7:0]       ctl_rd_data,
    input logic             cnt_wr_en,
    input logic [CNT_W-1:0] cnt_wr_data,
    input logic [CNT_W-1:0] cnt_rd_data,
    input logic             ovf_wr_en,
    input logic             ovf_wr_data,
    input logic             ovf_flag,
    input logic             irq
);
    p_strobe_bits_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rd_data[1:0] == 2'b00);

    p_bus_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr_en |=> cnt_rd_data == $past(cnt_wr_data));

    p_wrap_sets_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_rd_data == '1 && !cnt_wr_en && ctl_wr_en && ctl_wr_data[1]) |=> ovf_flag);

    p_flag_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> cnt_rd_data <= CNT_W'(1));

    p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !(ovf_wr_en && ovf_wr_data)) |=> ovf_flag);

    p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ovf_flag && ctl_rd_data[6]));

    p_step_limit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_wr_en |=> CNT_W'(cnt_rd_data - $past(cnt_rd_data)) <= CNT_W'(2));
endmodule

bind sibc_top sibc_top_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl_wr_data (ctl_wr_data),
    .ctl_wr_en   (ctl_wr_en),
    .ctl_rd_data (ctl_rd_data),
    .cnt_wr_en   (cnt_wr_en),
    .cnt_wr_data (cnt_wr_data),
    .cnt_rd_data (cnt_rd_data),
    .ovf_wr_en   (ovf_wr_en),
    .ovf_wr_data (ovf_wr_data),
    .ovf_flag    (ovf_flag),
    .irq         (irq)
);

// File: tb/sibc_top_test.sv
// Directed bench for sibc_top: one task per scenario, each checking its own results.
module sibc_top_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck_pin = 1'b0;
    logic       ctl_wr_en = 1'b0;
    logic [7:0] ctl_wr_data = '0;
    logic [7:0] ctl_rd_data;
    logic       cnt_wr_en = 1'b0;
    logic [3:0] cnt_wr_data = '0;
    logic [3:0] cnt_rd_data;
    logic       ovf_wr_en = 1'b0;
    logic       ovf_wr_data = 1'b0;
    logic       ovf_flag;
    logic       irq;

    int checks = 0;
    int errors = 0;
    logic [5:0] shadow = '0;

    always #4 clk = ~clk;

    sibc_top uut (
        .clk(clk), .rst_n(rst_n), .sck_pin(sck_pin),
        .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data), .ctl_rd_data(ctl_rd_data),
        .cnt_wr_en(cnt_wr_en), .cnt_wr_data(cnt_wr_data), .cnt_rd_data(cnt_rd_data),
        .ovf_wr_en(ovf_wr_en), .ovf_wr_data(ovf_wr_data), .ovf_flag(ovf_flag), .irq(irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Set control: shadow bits 7..2 plus strobe bits.
    task automatic ctl_set(input logic [5:0] st, input logic [1:0] strobes);
        @(negedge clk);
        shadow = st;
        ctl_wr_en = 1'b1; ctl_wr_data = {st, strobes};
        @(negedge clk);
        ctl_wr_en = 1'b0; ctl_wr_data = '0;
    endtask

    task automatic strobe();
        ctl_set(shadow, 2'b10);
    endtask

    task automatic cnt_load(input logic [3:0] v);
        @(negedge clk);
        cnt_wr_en = 1'b1; cnt_wr_data = v;
        @(negedge clk);
        cnt_wr_en = 1'b0;
    endtask

    task automatic flag_write(input logic b);
        @(negedge clk);
        ovf_wr_en = 1'b1; ovf_wr_data = b;
        @(negedge clk);
        ovf_wr_en = 1'b0; ovf_wr_data = 1'b0;
    endtask

    task automatic pin_toggle();
        @(negedge clk);
        sck_pin = ~sck_pin;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 ctl", ctl_rd_data, 8'h00);
        check("R1 cnt", {4'h0, cnt_rd_data}, 8'h00);
        check("R1 flag", {7'h0, ovf_flag}, 8'h00);
        check("R1 irq", {7'h0, irq}, 8'h00);
    endtask

    task automatic t_readback();
        ctl_set(6'b101100, 2'b11);
        check("R2 readback a", ctl_rd_data, 8'hB0);
        ctl_set(6'b010011, 2'b00);
        check("R2 readback b", ctl_rd_data, 8'h4C);
        ctl_set(6'b000000, 2'b00);
        cnt_load(4'h0);
    endtask

    task automatic t_strobe();
        cnt_load(4'h3);
        check("R3 load", {4'h0, cnt_rd_data}, 8'h03);
        strobe();
        check("R4 strobe cs00", {4'h0, cnt_rd_data}, 8'h04);
        ctl_set(6'b000001, 2'b10);
        check("R4 strobe cs01", {4'h0, cnt_rd_data}, 8'h05);
        ctl_set(6'b000001, 2'b01);
        check("R4 toggle no count", {4'h0, cnt_rd_data}, 8'h05);
        ctl_set(6'b000010, 2'b10);
        check("R4 strobe cs10", {4'h0, cnt_rd_data}, 8'h06);
        ctl_set(6'b000000, 2'b00);
    endtask

    task automatic t_load_priority();
        cnt_load(4'hF);
        @(negedge clk);
        cnt_wr_en = 1'b1; cnt_wr_data = 4'h9;
        ctl_wr_en = 1'b1; ctl_wr_data = {shadow, 2'b10};
        @(negedge clk);
        cnt_wr_en = 1'b0; ctl_wr_en = 1'b0; ctl_wr_data = '0;
        check("R3 load wins", {4'h0, cnt_rd_data}, 8'h09);
        check("R3 no overflow", {7'h0, ovf_flag}, 8'h00);
    endtask

    task automatic t_pin();
        cnt_load(4'h2);
        pin_toggle();
        check("R5 ignored cs00", {4'h0, cnt_rd_data}, 8'h02);
        pin_toggle();
        ctl_set(6'b000001, 2'b00);
        pin_toggle();
        check("R5 ignored cs01", {4'h0, cnt_rd_data}, 8'h02);
        pin_toggle();
        ctl_set(6'b000010, 2'b00);
        pin_toggle();
        check("R5 rising edge", {4'h0, cnt_rd_data}, 8'h03);
        pin_toggle();
        check("R5 falling edge", {4'h0, cnt_rd_data}, 8'h04);
        ctl_set(6'b001111, 2'b00);
        pin_toggle();
        check("R10 wire mode 11", {4'h0, cnt_rd_data}, 8'h05);
        ctl_set(6'b000110, 2'b00);
        pin_toggle();
        check("R10 wire mode 01", {4'h0, cnt_rd_data}, 8'h06);
    endtask

    task automatic t_edge_irq();
        ctl_set(6'b010010, 2'b00);
        cnt_load(4'hF);
        check("R6 flag clear before", {7'h0, ovf_flag}, 8'h00);
        pin_toggle();
        check("R6 one edge flag", {7'h0, ovf_flag}, 8'h01);
        check("R6 wrap to zero", {4'h0, cnt_rd_data}, 8'h00);
        check("R8 irq on", {7'h0, irq}, 8'h01);
        flag_write(1'b0);
        check("R7 write zero keeps", {7'h0, ovf_flag}, 8'h01);
        flag_write(1'b1);
        check("R7 clear", {7'h0, ovf_flag}, 8'h00);
        check("R8 irq off", {7'h0, irq}, 8'h00);
    endtask

    task automatic t_clear_collision();
        ctl_set(6'b000000, 2'b00);
        cnt_load(4'hF);
        strobe();
        check("R6 strobe wrap", {7'h0, ovf_flag}, 8'h01);
        check("R8 gated off", {7'h0, irq}, 8'h00);
        ctl_set(6'b010000, 2'b00);
        check("R8 immediate", {7'h0, irq}, 8'h01);
        cnt_load(4'hF);
        @(negedge clk);
        ovf_wr_en = 1'b1; ovf_wr_data = 1'b1;
        ctl_wr_en = 1'b1; ctl_wr_data = {shadow, 2'b10};
        @(negedge clk);
        ovf_wr_en = 1'b0; ovf_wr_data = 1'b0; ctl_wr_en = 1'b0; ctl_wr_data = '0;
        check("R7 overflow wins", {7'h0, ovf_flag}, 8'h01);
        flag_write(1'b1);
    endtask

    // Strobe lands in the cycle the synchronized edge is present.
    task automatic dual_step(input logic [3:0] start);
        cnt_load(start);
        @(negedge clk);
        sck_pin = ~sck_pin;
        @(negedge clk);
        @(negedge clk);
        ctl_wr_en = 1'b1; ctl_wr_data = {shadow, 2'b10};
        @(negedge clk);
        ctl_wr_en = 1'b0; ctl_wr_data = '0;
    endtask

    task automatic t_dual();
        ctl_set(6'b000010, 2'b00);
        dual_step(4'h5);
        check("R9 plus two", {4'h0, cnt_rd_data}, 8'h07);
        check("R9 no flag", {7'h0, ovf_flag}, 8'h00);
        dual_step(4'hE);
        check("R9 wrap count", {4'h0, cnt_rd_data}, 8'h00);
        check("R9 wrap flag", {7'h0, ovf_flag}, 8'h01);
        flag_write(1'b1);
        dual_step(4'hF);
        check("R9 from F", {4'h0, cnt_rd_data}, 8'h01);
        check("R9 from F flag", {7'h0, ovf_flag}, 8'h01);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_readback();
        t_strobe();
        t_load_priority();
        t_pin();
        t_edge_irq();
        t_clear_collision();
        t_dual();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #400000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule